// File: doc/BRIEF.md
# External Bus Slave Bridge

This block sits on the FPGA end of a processor's asynchronous SRAM-style external bus. It watches one active-low chip select, a word address, a 16-bit data bus, two active-low byte write enables and an active-low output enable. It turns each bus access into a single-cycle internal write or read of a small register file of 16-bit words. The bridge runs on the clock that the processor supplies for the bus, so every bus input is sampled directly with no synchronizer stages.

There are two ways to time an access. In fixed-latency mode the master programs its own wait states so that the access window covers the bridge's latency, and the acknowledge output stays idle. In handshake mode the bridge drives an active-low acknowledge once the write has committed or the read data is on the bus. It holds the acknowledge until the master releases the chip select. This lets the master end the access after a variable number of cycles.

The data bus is split into an input, an output and an output-enable, which feed a pad-level tri-state buffer outside the block. The register file holds eight words, and it is backed by the three word-index bits just above the ignored byte bit.

Top module: `ebus_bridge`

## Requirements
- R1: After reset every register word reads 0, `busDataOe` is 0 and `busAckN` is 1.
- R2: A write commits `busDataIn` into the addressed word using byte lanes chosen by `busEbN`. `busEbN[0]`=0 writes bits 7:0 and `busEbN[1]`=0 writes bits 15:8. A lane whose enable is 1 keeps its old value.
- R3: A write strobe that stays asserted for many cycles updates the register file exactly once. The update uses the data sampled in the first cycle in which chip select and at least one byte enable are low, and later data changes during the same strobe are ignored.
- R4: With chip select low and both byte enables high (`busEbN`=2'b11), no word is changed.
- R5: While `busCsN` is 1, byte enables and output enable have no effect: no word is changed and `busDataOe` stays 0.
- R6: The word index is `busAddr[3:1]`. Bit 0 is ignored, and bits 12:4 are ignored, so addresses alias every 16 byte addresses.
- R7: When `busCsN` and `busOeN` are both low in the cycle before a rising edge, read data and `busDataOe`=1 appear after the second rising edge. `busDataOe` falls in the same cycle that `busOeN` or `busCsN` goes high.
- R8: In handshake mode (`hsMode`=1), `busAckN` goes low after the edge where a write commits, or after the edge where read data is first driven. It stays low while `busCsN` stays low, and it returns high in the same cycle that `busCsN` goes high.
- R9: In fixed-latency mode (`hsMode`=0), `busAckN` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock supplied by the processor |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsMode | input | 1 | 1 = handshake (acknowledge) mode, 0 = fixed-latency mode |
| busCsN | input | 1 | Active-low chip select for this slave |
| busAddr | input | 13 | Byte address from the bus; bit 0 unused |
| busDataIn | input | 16 | Data from the pad toward the bridge |
| busEbN | input | 2 | Active-low byte write enables (bit 0 = low byte) |
| busOeN | input | 1 | Active-low output enable, marks a read |
| busDataOut | output | 16 | Read data toward the pad |
| busDataOe | output | 1 | Pad tri-state enable for busDataOut |
| busAckN | output | 1 | Active-low transfer acknowledge |

## Verification
A corrupted edge-detect register would show up as a lost write or a repeated write. The repeated write is visible as soon as the held-strobe test changes the data mid-access, and both faults are visible on the next read-back. A wrong drive or acknowledge register would put `busDataOe` or `busAckN` off by a cycle. The per-clock reference model in the bench catches that at the very next sample point. A wrong byte mask or wrong word index corrupts a lane or aliases the wrong word, and the read that follows each write pattern shows it within a few cycles.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  parameter int DATA_W = 16;
  parameter int LANE_W = 8;
  parameter int LANES  = DATA_W / LANE_W;
  parameter int WORDS  = 8;
  parameter int IDX_W  = $clog2(WORDS);
  parameter int ADDR_W = 13;

  // control-to-datapath strobes
  typedef struct packed {
    logic             wrEn;
    logic [LANES-1:0] wrMask;
    logic             rdEn;
    logic [IDX_W-1:0] idx;
  } ebStrobe_t;
endpackage

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsMode,
  input  logic              busCsN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [LANES-1:0]  busEbN,
  input  logic              busOeN,
  output ebStrobe_t         strobe,
  output logic [DATA_W-1:0] wrData,
  output logic              driveQ,
  output logic              ackQ
);
  logic              csQ;
  logic              oeQ;
  logic [LANES-1:0]  ebQ;
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] dataQ;
  logic              wrCondPrev;
  logic              wrCond;
  logic              rdCond;
  logic              wrPulse;
  logic              ackSet;

  // one register stage on every bus input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csQ   <= 1'b1;
      oeQ   <= 1'b1;
      ebQ   <= '1;
      idxQ  <= '0;
      dataQ <= '0;
    end else begin
      csQ   <= busCsN;
      oeQ   <= busOeN;
      ebQ   <= busEbN;
      idxQ  <= busAddr[IDX_W:1];
      dataQ <= busDataIn;
    end
  end

  assign wrCond  = ~csQ & ~(&ebQ);
  assign rdCond  = ~csQ & ~oeQ;
  assign wrPulse = wrCond & ~wrCondPrev;
  assign ackSet  = hsMode & (wrPulse | (rdCond & ~driveQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrCondPrev <= 1'b0;
      driveQ     <= 1'b0;
      ackQ       <= 1'b0;
    end else begin
      wrCondPrev <= wrCond;
      driveQ     <= rdCond;
      if (busCsN || !hsMode) ackQ <= 1'b0;
      else if (ackSet)       ackQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.wrEn   = wrPulse;
    strobe.wrMask = ~ebQ;
    strobe.rdEn   = rdCond;
    strobe.idx    = idxQ;
  end

  assign wrData = dataQ;
endmodule

// File: rtl/ebus_dpath.sv
module ebus_dpath
  import ebus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ebStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regs [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[w][b*LANE_W +: LANE_W] <= '0;
        else if (strobe.wrEn && strobe.wrMask[b] && (strobe.idx == IDX_W'(w)))
          regs[w][b*LANE_W +: LANE_W] <= wrData[b*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdData <= '0;
    else if (strobe.rdEn) rdData <= regs[strobe.idx];
  end
endmodule

// File: rtl/ebus_bridge.sv
module ebus_bridge
  import ebus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsMode,
  input  logic              busCsN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [LANES-1:0]  busEbN,
  input  logic              busOeN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              busAckN
);
  ebStrobe_t         ctrlBus;
  logic [DATA_W-1:0] wrData;
  logic              driveQ;
  logic              ackQ;

  ebus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hsMode(hsMode), .busCsN(busCsN),
    .busAddr(busAddr), .busDataIn(busDataIn), .busEbN(busEbN),
    .busOeN(busOeN), .strobe(ctrlBus), .wrData(wrData),
    .driveQ(driveQ), .ackQ(ackQ)
  );

  ebus_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(ctrlBus), .wrData(wrData),
    .rdData(busDataOut)
  );

  // live pin gating releases the bus and acknowledge without a clock delay
  assign busDataOe = driveQ & ~busOeN & ~busCsN;
  assign busAckN   = ~(ackQ & ~busCsN);
endmodule

// File: rtl/ebus_bridge_chk.sv
module ebus_bridge_chk
  import ebus_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hsMode,
  input logic             busCsN,
  input logic             busOeN,
  input logic             busDataOe,
  input logic             busAckN,
  input logic             wrEn,
  input logic [LANES-1:0] wrMask
);
  p_drive_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busDataOe |-> $past(!busCsN && !busOeN, 2));

  p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> !wrEn);

  p_write_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> $past(!busCsN));

  p_mask_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (wrMask != '0));

  p_ack_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busAckN |-> $past(!busCsN));

  p_ack_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busAckN |-> $past(hsMode));
endmodule

bind ebus_bridge ebus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hsMode(hsMode), .busCsN(busCsN),
  .busOeN(busOeN), .busDataOe(busDataOe), .busAckN(busAckN),
  .wrEn(ctrlBus.wrEn), .wrMask(ctrlBus.wrMask)
);

// File: tb/ebus_bridge_test.sv
`timescale 1ns/1ps
module ebus_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsMode = 1'b0;
  logic        busCsN = 1'b1;
  logic [12:0] busAddr = '0;
  logic [15:0] busDataIn = '0;
  logic [1:0]  busEbN = 2'b11;
  logic        busOeN = 1'b1;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic        busAckN;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ebus_bridge uut (
    .clk(clk), .rst_n(rst_n), .hsMode(hsMode), .busCsN(busCsN),
    .busAddr(busAddr), .busDataIn(busDataIn), .busEbN(busEbN),
    .busOeN(busOeN), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busAckN(busAckN)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced at each rising edge
  logic [15:0] mem [8];
  bit   mCs = 1, mOe = 1, mPrevWr = 0, mDrv = 0, mAck = 0;
  logic [1:0]  mEb = 2'b11;
  int          mIdx = 0;
  logic [15:0] mData = '0, mRd = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = '0;
      mCs = 1; mOe = 1; mEb = 2'b11; mPrevWr = 0; mDrv = 0; mAck = 0; mRd = '0;
    end else begin
      bit wr, pulse, rd, setA;
      wr    = !mCs && (mEb != 2'b11);
      pulse = wr && !mPrevWr;
      rd    = !mCs && !mOe;
      setA  = hsMode && (pulse || (rd && !mDrv));
      if (rd) mRd = mem[mIdx];
      mAck  = (busCsN || !hsMode) ? 0 : (mAck || setA);
      mDrv  = rd;
      if (pulse) begin
        if (!mEb[0]) mem[mIdx][7:0]  = mData[7:0];
        if (!mEb[1]) mem[mIdx][15:8] = mData[15:8];
      end
      mPrevWr = wr;
      mCs = busCsN; mOe = busOeN; mEb = busEbN;
      mIdx = int'(busAddr[3:1]); mData = busDataIn;
    end
    #2;
    if (rst_n && !done) begin
      bit expOe;
      expOe = mDrv && !busOeN && !busCsN;
      check(busDataOe == expOe, "R7", 16'(busDataOe), 16'(expOe));
      check(busAckN == !(mAck && !busCsN), "R8", 16'(busAckN), 16'(!(mAck && !busCsN)));
      if (expOe) check(busDataOut == mRd, "R2", busDataOut, mRd);
    end
  end

  task automatic busWrite(input logic [12:0] a, input logic [15:0] d, input logic [1:0] eb);
    @(negedge clk);
    busCsN = 0; busAddr = a; busDataIn = d; busEbN = eb;
    repeat (3) @(negedge clk);
    busCsN = 1; busEbN = 2'b11;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [12:0] a, output logic [15:0] d);
    @(negedge clk);
    busCsN = 0; busOeN = 0; busAddr = a;
    repeat (3) @(posedge clk);
    #2 d = busDataOut;
    @(negedge clk);
    busCsN = 1; busOeN = 1;
    @(negedge clk);
  endtask

  task automatic expectWord(input logic [12:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    busRead(a, v);
    check(v == exp, req, v, exp);
  endtask

  initial begin
    foreach (mem[i]) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busDataOe == 0, "R1", 16'(busDataOe), 16'd0);
    check(busAckN == 1, "R1", 16'(busAckN), 16'd1);
    for (int i = 0; i < 8; i++) expectWord(13'(i * 2), 16'h0000, "R1");

    // R2 byte-lane writes
    busWrite(13'h004, 16'hA55A, 2'b00);
    expectWord(13'h004, 16'hA55A, "R2");
    busWrite(13'h004, 16'h1234, 2'b10);
    expectWord(13'h004, 16'hA534, "R2");
    busWrite(13'h004, 16'h5678, 2'b01);
    expectWord(13'h004, 16'h5634, "R2");

    // R4 select low, both lanes disabled
    busWrite(13'h004, 16'hFFFF, 2'b11);
    expectWord(13'h004, 16'h5634, "R4");

    // R5 deselected activity
    @(negedge clk);
    busCsN = 1; busAddr = 13'h004; busDataIn = 16'h0F0F; busEbN = 2'b00; busOeN = 0;
    repeat (3) @(posedge clk);
    #2 check(busDataOe == 0, "R5", 16'(busDataOe), 16'd0);
    @(negedge clk);
    busEbN = 2'b11; busOeN = 1;
    expectWord(13'h004, 16'h5634, "R5");

    // R3 held strobe, data changes mid-access
    @(negedge clk);
    busCsN = 0; busAddr = 13'h00A; busDataIn = 16'h1111; busEbN = 2'b00;
    repeat (3) @(negedge clk);
    busDataIn = 16'h2222;
    repeat (3) @(negedge clk);
    busCsN = 1; busEbN = 2'b11;
    expectWord(13'h00A, 16'h1111, "R3");

    // R6 index from bits 3:1, bit 0 and upper bits ignored
    busWrite(13'h007, 16'h3333, 2'b00);
    expectWord(13'h006, 16'h3333, "R6");
    busWrite(13'h018, 16'h4444, 2'b00);
    expectWord(13'h008, 16'h4444, "R6");
    expectWord(13'h1F8, 16'h4444, "R6");

    // R7 read latency and release
    @(negedge clk);
    busCsN = 0; busOeN = 0; busAddr = 13'h008;
    @(posedge clk); #2 check(busDataOe == 0, "R7", 16'(busDataOe), 16'd0);
    @(posedge clk); #2 check(busDataOe == 1, "R7", 16'(busDataOe), 16'd1);
    check(busDataOut == 16'h4444, "R7", busDataOut, 16'h4444);
    @(negedge clk);
    busOeN = 1;
    #1 check(busDataOe == 0, "R7", 16'(busDataOe), 16'd0);
    @(negedge clk);
    busCsN = 1;
    @(negedge clk);

    // R9 fixed mode: no acknowledge
    @(negedge clk);
    busCsN = 0; busAddr = 13'h002; busDataIn = 16'hBEEF; busEbN = 2'b00;
    repeat (3) @(posedge clk);
    #2 check(busAckN == 1, "R9", 16'(busAckN), 16'd1);
    @(negedge clk);
    busCsN = 1; busEbN = 2'b11;
    @(negedge clk);

    // R8 handshake write and read
    hsMode = 1;
    @(negedge clk);
    busCsN = 0; busAddr = 13'h00C; busDataIn = 16'hC0DE; busEbN = 2'b00;
    @(posedge clk); #2 check(busAckN == 1, "R8", 16'(busAckN), 16'd1);
    @(posedge clk); #2 check(busAckN == 0, "R8", 16'(busAckN), 16'd0);
    repeat (3) @(posedge clk);
    #2 check(busAckN == 0, "R8", 16'(busAckN), 16'd0);
    @(negedge clk);
    busCsN = 1; busEbN = 2'b11;
    #1 check(busAckN == 1, "R8", 16'(busAckN), 16'd1);
    @(negedge clk);
    busCsN = 0; busOeN = 0; busAddr = 13'h00C;
    @(posedge clk); @(posedge clk);
    #2 check(busAckN == 0, "R8", 16'(busAckN), 16'd0);
    check(busDataOut == 16'hC0DE, "R8", busDataOut, 16'hC0DE);
    @(negedge clk);
    busCsN = 1; busOeN = 1;
    #1 check(busAckN == 1, "R8", 16'(busAckN), 16'd1);
    repeat (2) @(negedge clk);
    hsMode = 0;
    expectWord(13'h002, 16'hBEEF, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule